// File: doc/BRIEF.md
# RTC Sub-Second Increment Updater

This block turns a low-frequency oscillator measurement into the sub-second increment used by a real-time clock. The measurement is a count of fast reference cycles taken across 32 periods of the slow oscillator. The block scales that count in fixed point and can optionally correct it for the drift of a high-precision oscillator, using a signed offset word. It then filters the result against the increment the clock is using now and publishes it.

After reset, or after software re-arms it, the first measurement is applied unfiltered so the clock converges quickly. Every later measurement is averaged half-and-half with the current increment. The result leaves the block as a low half-word, then a high half-word one cycle later, then a single-cycle update request. A new calibration run (`run_start`) flushes any measurement still in flight, so a stale increment is never flagged. Only one measurement is processed at a time.

Top module: `rtc_subsec_updater`

## Requirements
- R1: The scaled increment equals floor(meas_count × 45813 / 256), with meas_count taken as unsigned. It is exact for every count up to all ones (24 bits by default), with no overflow.
- R2: When drift_en is high at the accepting edge, the value from R1 is corrected by adding ((scaled >>> 4) × (drift_ofs >>> 3)) >>> 15. drift_ofs is a signed two's-complement word, the shifts are arithmetic, and the sum is taken modulo 2^32.
- R3: After reset or a first_rearm pulse, the next measurement that reaches the filter is published unfiltered. That measurement clears the first-sample flag.
- R4: While the first-sample flag is clear, the published value is ((cur_inc & 0x00FFFFFF) + new) mod 2^32, shifted right by one. cur_inc is sampled at the accepting edge.
- R5: inc_lo takes bits 15:0 of the result at the third rising edge after the accepting edge. inc_hi takes bits 31:16 one edge later, and inc_lo is already updated when this happens.
- R6: upd_req goes high for exactly one cycle, at the fifth edge after the accepting edge, one edge after inc_hi is written. inc_lo and inc_hi do not change on that edge.
- R7: run_start cancels any measurement in flight, so no upd_req pulse follows it. A meas_valid in the same cycle as run_start is ignored. Halves that were already written keep their values.
- R8: meas_valid is ignored at every edge from one edge after the accepting edge through the edge that raises upd_req.
- R9: A measurement cancelled by run_start before it reaches the filter leaves the first-sample flag unchanged.
- R10: While rst is high and after it is released, inc_lo and inc_hi read 0 and upd_req reads 0. The first-sample flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Measurement strobe |
| meas_count | input | 24 | Reference cycles counted over 32 slow periods |
| cur_inc | input | 32 | Increment currently in use (low 24 bits used) |
| drift_en | input | 1 | Apply drift correction to this measurement |
| drift_ofs | input | 16 | Signed drift offset word |
| first_rearm | input | 1 | Set the first-sample flag again |
| run_start | input | 1 | New calibration run: flush in-flight work |
| inc_lo | output | 16 | Published increment, bits 15:0 |
| inc_hi | output | 16 | Published increment, bits 31:16 |
| upd_req | output | 1 | Single-cycle update request |

## Verification
Properties checked on every cycle:
- upd_req never lasts more than one cycle, and both halves are stable when it fires.
- run_start suppresses a request in the next cycle.
- At most one pipeline stage holds a measurement at any time.
- The first-sample flag drops after a measurement is filtered.

Only the bench scenarios can show the following:
- The arithmetic: scaling, drift in both signs, masking of the current increment, averaging and the saturated count.
- The exact latency of each half and of the request.
- Re-arming the filter bypass.
- A cancelled first measurement leaving the bypass armed, and measurements dropped while busy.

// File: rtl/rtc_inc_pkg.sv
package rtc_inc_pkg;
  // fixed-point scale applied to the 32-period count
  localparam int unsigned SCALE_MUL   = 45813;
  localparam int unsigned SCALE_SHIFT = 8;
  // drift correction shift amounts
  localparam int unsigned DRIFT_PRE   = 4;
  localparam int unsigned OFS_PRE     = 3;
  localparam int unsigned DRIFT_POST  = 15;
endpackage

// File: rtl/inc_scaler.sv
module inc_scaler
  import rtc_inc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int OFS_W = 16,
  parameter int INC_W = 32,
  parameter int MUL   = SCALE_MUL,
  parameter int SHIFT = SCALE_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_vld,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [INC_W-1:0] in_old,
  input  logic             in_den,
  input  logic [OFS_W-1:0] in_ofs,
  output logic             out_vld,
  output logic [INC_W-1:0] out_new,
  output logic [INC_W-1:0] out_old,
  output logic [1:0]       stg_vld
);
  localparam int MUL_W  = $clog2(MUL + 1);
  localparam int PROD_W = CNT_W + MUL_W;
  localparam int A_W    = INC_W + 1;
  localparam int P_W    = A_W + OFS_W;

  // stage 1: fixed-point scale
  logic [PROD_W-1:0]      prod_c;
  logic                   s1_vld;
  logic [INC_W-1:0]       s1_scaled;
  logic [INC_W-1:0]       s1_old;
  logic                   s1_den;
  logic signed [OFS_W-1:0] s1_ofs;

  assign prod_c = PROD_W'(in_cnt) * PROD_W'(MUL);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
    end
    if (in_vld) begin
      s1_scaled <= INC_W'(prod_c >> SHIFT);
      s1_old    <= in_old;
      s1_den    <= in_den;
      s1_ofs    <= $signed(in_ofs);
    end
  end

  // stage 2: optional drift correction, signed
  logic signed [A_W-1:0]   a_c;
  logic signed [OFS_W-1:0] b_c;
  logic signed [P_W-1:0]   p_c;
  logic [INC_W-1:0]        corr_c;

  assign a_c    = $signed({1'b0, s1_scaled}) >>> DRIFT_PRE;
  assign b_c    = s1_ofs >>> OFS_PRE;
  assign p_c    = P_W'(a_c) * P_W'(b_c);
  assign corr_c = INC_W'(p_c >>> DRIFT_POST);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= s1_vld;
    end
    if (s1_vld) begin
      out_new <= s1_den ? (s1_scaled + corr_c) : s1_scaled;
      out_old <= s1_old;
    end
  end

  assign stg_vld = {out_vld, s1_vld};
endmodule

// File: rtl/inc_filter.sv
module inc_filter #(
  parameter int INC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             rearm,
  input  logic             in_vld,
  input  logic [INC_W-1:0] in_new,
  input  logic [INC_W-1:0] in_old,
  output logic             out_vld,
  output logic [INC_W-1:0] out_val
);
  logic             first_q;
  logic [INC_W-1:0] sum_c;
  logic [INC_W-1:0] avg_c;
  logic             take_c;

  assign take_c = in_vld && !flush;
  assign sum_c  = in_old + in_new;
  assign avg_c  = sum_c >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
    end else if (rearm) begin
      first_q <= 1'b1;
    end else if (take_c) begin
      first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_val <= '0;
    end else begin
      out_vld <= take_c;
      if (take_c) begin
        out_val <= first_q ? in_new : avg_c;
      end
    end
  end

  // R3: a filtered sample drops the bypass flag unless re-armed
  a_r3_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (take_c && !rearm) |=> !first_q);
endmodule

// File: rtl/inc_publisher.sv
module inc_publisher #(
  parameter int INC_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  in_vld,
  input  logic [INC_W-1:0]      in_val,
  output logic [HALF_W-1:0]     lo,
  output logic [INC_W-HALF_W-1:0] hi,
  output logic                  req,
  output logic [1:0]            stg_vld
);
  localparam int HI_W = INC_W - HALF_W;

  logic            lo_v;
  logic            hi_v;
  logic [HI_W-1:0] hold_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo      <= '0;
      hi      <= '0;
      hold_hi <= '0;
      lo_v    <= 1'b0;
      hi_v    <= 1'b0;
      req     <= 1'b0;
    end else begin
      lo_v <= in_vld && !flush;
      hi_v <= lo_v && !flush;
      req  <= hi_v && !flush;
      if (in_vld && !flush) begin
        lo      <= in_val[HALF_W-1:0];
        hold_hi <= in_val[INC_W-1:HALF_W];
      end
      if (lo_v && !flush) begin
        hi <= hold_hi;
      end
    end
  end

  assign stg_vld = {hi_v, lo_v};

  // R6: request is one cycle wide
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  // R6: both halves already settled when the request shows
  a_r6_halves_settled: assert property (@(posedge clk) disable iff (rst)
    req |-> ($stable(lo) && $stable(hi)));
  // R7: a new run blocks any request
  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (rst)
    flush |=> !req);
endmodule

// File: rtl/rtc_subsec_updater.sv
module rtc_subsec_updater
  import rtc_inc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int OFS_W  = 16,
  parameter int INC_W  = 32,
  parameter int OLD_W  = 24,
  parameter int HALF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    meas_valid,
  input  logic [CNT_W-1:0]        meas_count,
  input  logic [INC_W-1:0]        cur_inc,
  input  logic                    drift_en,
  input  logic [OFS_W-1:0]        drift_ofs,
  input  logic                    first_rearm,
  input  logic                    run_start,
  output logic [HALF_W-1:0]       inc_lo,
  output logic [INC_W-HALF_W-1:0] inc_hi,
  output logic                    upd_req
);
  localparam logic [INC_W-1:0] OLD_MASK = INC_W'((64'd1 << OLD_W) - 64'd1);

  logic [1:0]       sc_stg;
  logic [1:0]       pb_stg;
  logic             sc_vld;
  logic [INC_W-1:0] sc_new;
  logic [INC_W-1:0] sc_old;
  logic             fl_vld;
  logic [INC_W-1:0] fl_val;
  logic             busy_c;
  logic             accept_c;
  logic [INC_W-1:0] old_masked;

  assign busy_c     = |{sc_stg, fl_vld, pb_stg};
  assign accept_c   = meas_valid && !run_start && !busy_c;
  assign old_masked = cur_inc & OLD_MASK;

  inc_scaler #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .INC_W(INC_W),
    .MUL(SCALE_MUL), .SHIFT(SCALE_SHIFT)
  ) u_scale (
    .clk(clk), .rst(rst), .flush(run_start),
    .in_vld(accept_c), .in_cnt(meas_count), .in_old(old_masked),
    .in_den(drift_en), .in_ofs(drift_ofs),
    .out_vld(sc_vld), .out_new(sc_new), .out_old(sc_old),
    .stg_vld(sc_stg)
  );

  inc_filter #(.INC_W(INC_W)) u_filt (
    .clk(clk), .rst(rst), .flush(run_start), .rearm(first_rearm),
    .in_vld(sc_vld), .in_new(sc_new), .in_old(sc_old),
    .out_vld(fl_vld), .out_val(fl_val)
  );

  inc_publisher #(.INC_W(INC_W), .HALF_W(HALF_W)) u_pub (
    .clk(clk), .rst(rst), .flush(run_start),
    .in_vld(fl_vld), .in_val(fl_val),
    .lo(inc_lo), .hi(inc_hi), .req(upd_req), .stg_vld(pb_stg)
  );

  // R8: only one measurement travels the pipeline at a time
  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sc_stg, fl_vld, pb_stg}));
endmodule

// File: tb/tb_rtc_subsec_updater.sv
module tb_rtc_subsec_updater;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        meas_valid = 1'b0;
  logic [23:0] meas_count = '0;
  logic [31:0] cur_inc = '0;
  logic        drift_en = 1'b0;
  logic [15:0] drift_ofs = '0;
  logic        first_rearm = 1'b0;
  logic        run_start = 1'b0;
  logic [15:0] inc_lo;
  logic [15:0] inc_hi;
  logic        upd_req;

  always #5 clk = ~clk;

  rtc_subsec_updater dut (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_count(meas_count),
    .cur_inc(cur_inc), .drift_en(drift_en), .drift_ofs(drift_ofs),
    .first_rearm(first_rearm), .run_start(run_start),
    .inc_lo(inc_lo), .inc_hi(inc_hi), .upd_req(upd_req)
  );

  typedef struct {
    logic [15:0] lo;
    logic [15:0] hi;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    n_pulse = 0;
  bit    prev_req = 1'b0;
  bit    m_first = 1'b1;
  logic [15:0] last_hi = '0;
  logic [15:0] last_lo = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [23:0] c, input bit den,
      input logic signed [15:0] ofs, input logic [31:0] old, input bit first);
    longint sc, a, b, p, nw, s;
    sc = (longint'(c) * 45813) >>> 8;
    nw = sc;
    if (den) begin
      a  = sc >>> 4;
      b  = longint'(ofs) >>> 3;
      p  = (a * b) >>> 15;
      nw = sc + p;
    end
    nw = nw & 64'hFFFF_FFFF;
    if (first) return nw[31:0];
    s = ((longint'(old) & 64'h00FF_FFFF) + nw) & 64'hFFFF_FFFF;
    s = s >> 1;
    return s[31:0];
  endfunction

  // monitor: pops expected items when the request fires
  always @(negedge clk) begin
    if (!rst) begin
      if (upd_req) begin
        n_pulse++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected upd_req", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(inc_lo == e.lo, e.tag, "inc_lo at request", {16'd0, inc_lo}, {16'd0, e.lo});
          chk(inc_hi == e.hi, e.tag, "inc_hi at request", {16'd0, inc_hi}, {16'd0, e.hi});
          chk(cyc == e.cyc, "R6", "request cycle", cyc, e.cyc);
        end
      end
      if (prev_req && upd_req) chk(1'b0, "R6", "request wider than one cycle", 32'd2, 32'd1);
      prev_req = upd_req;
    end
  end

  // driver: one measurement, optional order check, keeps meas_valid high
  // while busy when busy_hold is set (R8)
  task automatic measure(input logic [23:0] c, input bit den, input logic signed [15:0] ofs,
                         input logic [31:0] old, input string tag,
                         input bit chk_order, input bit busy_hold);
    exp_t e;
    logic [31:0] v;
    @(negedge clk);
    meas_count = c; drift_en = den; drift_ofs = ofs; cur_inc = old; meas_valid = 1'b1;
    @(posedge clk);
    #1;
    v = model(c, den, ofs, old, m_first);
    m_first = 1'b0;
    e.lo = v[15:0]; e.hi = v[31:16]; e.cyc = cyc + 5; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    if (busy_hold) begin
      meas_count = 24'd9999; cur_inc = 32'h0000_0005; drift_en = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      meas_valid = 1'b0;
      repeat (6) @(negedge clk);
    end else begin
      meas_valid = 1'b0;
      if (chk_order) begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(inc_lo == v[15:0], "R5", "inc_lo after third edge", {16'd0, inc_lo}, {16'd0, v[15:0]});
        chk(inc_hi == last_hi, "R5", "inc_hi not yet written", {16'd0, inc_hi}, {16'd0, last_hi});
        @(posedge clk);
        @(negedge clk);
        chk(inc_hi == v[31:16], "R5", "inc_hi after fourth edge", {16'd0, inc_hi}, {16'd0, v[31:16]});
        chk(upd_req == 1'b0, "R6", "no request before hi settles", {31'd0, upd_req}, 32'd0);
        repeat (4) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    last_lo = v[15:0];
    last_hi = v[31:16];
  endtask

  task automatic rearm();
    @(negedge clk);
    first_rearm = 1'b1;
    @(negedge clk);
    first_rearm = 1'b0;
    m_first = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int np;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(inc_lo == 16'd0, "R10", "inc_lo after reset", {16'd0, inc_lo}, 32'd0);
    chk(inc_hi == 16'd0, "R10", "inc_hi after reset", {16'd0, inc_hi}, 32'd0);
    chk(upd_req == 1'b0, "R10", "upd_req after reset", {31'd0, upd_req}, 32'd0);

    // R1 R3: first sample unfiltered, order check R5
    measure(24'd23437, 1'b0, 16'sd0, 32'h0000_0000, "R1", 1'b1, 1'b0);
    // R4: averaged with masked old value
    measure(24'd23500, 1'b0, 16'sd0, 32'hAB3F_1234, "R4", 1'b0, 1'b0);
    // R2: positive and negative drift
    measure(24'd23437, 1'b1, 16'sd2000, 32'h003F_0000, "R2", 1'b0, 1'b0);
    measure(24'd23437, 1'b1, -16'sd3000, 32'h0040_0100, "R2", 1'b0, 1'b0);
    // R1: saturated count, order check again
    measure(24'hFF_FFFF, 1'b0, 16'sd0, 32'h00FF_FFFF, "R1", 1'b1, 1'b0);
    // R3: re-armed bypass
    rearm();
    measure(24'd20000, 1'b0, 16'sd0, 32'h0012_3456, "R3", 1'b0, 1'b0);

    // R7 R9: cancel a re-armed first sample before it is filtered
    rearm();
    np = n_pulse;
    @(negedge clk);
    meas_count = 24'd30000; cur_inc = 32'h0; drift_en = 1'b0; meas_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    meas_valid = 1'b0; run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_pulse == np, "R7", "cancelled measurement pulsed", n_pulse, np);
    chk(inc_lo == last_lo, "R7", "inc_lo kept after cancel", {16'd0, inc_lo}, {16'd0, last_lo});
    chk(inc_hi == last_hi, "R7", "inc_hi kept after cancel", {16'd0, inc_hi}, {16'd0, last_hi});
    measure(24'd21000, 1'b0, 16'sd0, 32'h0000_0001, "R9", 1'b0, 1'b0);

    // R7: meas_valid together with run_start is ignored
    np = n_pulse;
    @(negedge clk);
    meas_count = 24'd12345; meas_valid = 1'b1; run_start = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0; run_start = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_pulse == np, "R7", "meas with run_start pulsed", n_pulse, np);
    chk(inc_lo == last_lo, "R7", "inc_lo kept with run_start", {16'd0, inc_lo}, {16'd0, last_lo});

    // R8: strobes while busy are dropped
    np = n_pulse;
    measure(24'd22222, 1'b0, 16'sd0, 32'h0040_0000, "R8", 1'b0, 1'b1);
    chk(n_pulse == np + 1, "R8", "pulses for busy strobes", n_pulse, np + 1);
    chk(inc_lo == last_lo, "R8", "inc_lo holds accepted value", {16'd0, inc_lo}, {16'd0, last_lo});

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "missing requests", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule